// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software running on a single clock. A down counter is loaded with a start value and, once the watchdog is armed, decrements on every clock cycle in which the count-enable input is high and the pause input is low. If software does not restart the counter with a keyed write before it runs out, a timeout occurs. Depending on the selected response, the timeout either drives the system reset output at once, or first raises an interrupt and drives reset only if a second full period then expires without a restart.

Software reaches the block through a simple APB-style slave port: a setup phase with `psel` and an access phase with `penable`, with no wait states. Five registers sit at word offsets. CTRL (0x00) holds the arm bit in bit 0, the response select in bit 1 and the reset pulse length code in bits 11:8. PERIOD (0x04) holds a 4-bit exponent n in bits 3:0. KICK (0x08) is write-only and takes the restart key. COUNT (0x0C) returns the live counter value. STATUS (0x10) returns the interrupt flag in bit 0. The start value is 2^(BASE_EXP+n) cycles; `BASE_EXP` is 16 by default.

The controller is a four-state machine. OFF is the state after reset. In RUN the counter counts, and in WARN the interrupt is pending while the counter counts a second period. In BITE the reset pulse is being driven. The transitions are named as follows. arm_start takes OFF to RUN when the arm bit is seen. first_expiry takes RUN to WARN when the response is interrupt-first. hard_expiry takes RUN to BITE when the response is immediate. kick_rescue takes WARN back to RUN on a valid restart. second_expiry takes WARN to BITE. pulse_done takes BITE back to RUN with a reload once the pulse has lasted its full length. A valid restart in RUN is kick_reload, which stays in RUN and reloads the counter.

Top module: `wdog_dual_stage`

## Requirements
- R1: After reset, `irq` and `sys_rst` are low, CTRL reads DEF_PULSE in bits 11:8 with the arm and response bits at 0, PERIOD reads DEF_SEL, and COUNT reads 0.
- R2: Setting the arm bit (CTRL bit 0) loads COUNT with S = 2^(BASE_EXP+n) one cycle after the write completes. From the following cycle the count drops by one per qualified cycle, and the S-th qualified cycle is a timeout that also reloads S.
- R3: A cycle with `cnt_en` low does not decrement the counter.
- R4: While `pause` is high the counter holds its value, whatever the level of `cnt_en`.
- R5: With CTRL bit 1 = 0 (immediate response), a timeout raises `sys_rst` at once and leaves `irq` low.
- R6: With CTRL bit 1 = 1 (interrupt first), the first timeout raises `irq` and the counter starts a second period. The timeout at the end of that period raises `sys_rst`, even if the interrupt was cleared in the meantime.
- R7: `sys_rst` stays high for exactly L+1 cycles, where L is CTRL bits 11:8. When it falls, `irq` is low, the counter has been reloaded, and counting resumes.
- R8: Once armed, the watchdog cannot be disarmed by a write: CTRL bit 0 keeps reading 1 and timeouts still occur. Only reset clears it.
- R9: A KICK write whose bits 7:0 equal 0x76 while armed reloads the counter to S, clears `irq`, and returns WARN to RUN. Any other value, or any write while unarmed, changes nothing.
- R10: A read of STATUS returns `irq` in bit 0 and clears the flag without changing the counter.
- R11: A write to PERIOD does not alter a running count. The new S applies from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select (setup and access phases) |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Register byte offset |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid while psel is high and pwrite is low |
| cnt_en | input | 1 | Count enable; gates each decrement |
| pause | input | 1 | Holds the counter while high |
| irq | output | 1 | Interrupt from the first timeout in interrupt-first mode |
| sys_rst | output | 1 | System reset pulse |

## Verification
The hardest situation to reach is the second timeout in interrupt-first mode after the interrupt has already been cleared by a STATUS read. The bench stops the count by holding `cnt_en` low while it reads STATUS, so the read costs no ticks. It then counts the qualified edges itself until `sys_rst` rises and expects exactly one more full period. The sweep covers both response modes, several period exponents and three enable and pause patterns on a small-exponent configuration. Every timeout is predicted by counting the edges at which the bench itself held `cnt_en` high and `pause` low.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_WARN = 2'd2,
        ST_BITE = 2'd3
    } wd_state_e;

    localparam logic [4:0] OFS_CTRL   = 5'h00;
    localparam logic [4:0] OFS_PERIOD = 5'h04;
    localparam logic [4:0] OFS_KICK   = 5'h08;
    localparam logic [4:0] OFS_COUNT  = 5'h0C;
    localparam logic [4:0] OFS_STATUS = 5'h10;

    localparam logic [7:0] KICK_KEY = 8'h76;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32,
    parameter int SEL_W     = 4,
    parameter int LEN_W     = 4,
    parameter int CNT_W     = 32,
    parameter int DEF_SEL   = 0,
    parameter int DEF_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              irq,
    output logic              arm,
    output logic              warn_first,
    output logic [LEN_W-1:0]  pulse_len,
    output logic [SEL_W-1:0]  sel,
    output logic              kick_ok,
    output logic              clr_irq
);

    logic wr_acc, rd_acc;
    logic [DATA_W-1:0] cnt_rd, ctrl_rd, per_rd;
    logic unused_wdata;

    assign wr_acc = psel & penable & pwrite;
    assign rd_acc = psel & penable & ~pwrite;
    assign unused_wdata = ^pwdata;

    // keyed restart: only the key in the low byte counts
    assign kick_ok = wr_acc && (paddr == ADDR_W'(OFS_KICK)) && (pwdata[7:0] == KICK_KEY);
    assign clr_irq = rd_acc && (paddr == ADDR_W'(OFS_STATUS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm        <= 1'b0;
            warn_first <= 1'b0;
            pulse_len  <= LEN_W'(DEF_PULSE);
            sel        <= SEL_W'(DEF_SEL);
        end else if (wr_acc) begin
            if (paddr == ADDR_W'(OFS_CTRL)) begin
                if (pwdata[0]) arm <= 1'b1;   // sticky: a zero never clears it
                warn_first <= pwdata[1];
                pulse_len  <= pwdata[8 +: LEN_W];
            end
            if (paddr == ADDR_W'(OFS_PERIOD)) begin
                sel <= pwdata[SEL_W-1:0];
            end
        end
    end

    generate
        if (CNT_W >= DATA_W) begin : g_cnt_trunc
            assign cnt_rd = cnt_val[DATA_W-1:0];
        end else begin : g_cnt_ext
            assign cnt_rd = {{(DATA_W-CNT_W){1'b0}}, cnt_val};
        end
    endgenerate

    always_comb begin
        ctrl_rd              = '0;
        ctrl_rd[0]           = arm;
        ctrl_rd[1]           = warn_first;
        ctrl_rd[8 +: LEN_W]  = pulse_len;
        per_rd               = '0;
        per_rd[SEL_W-1:0]    = sel;
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            unique case (paddr)
                ADDR_W'(OFS_CTRL):   prdata = ctrl_rd;
                ADDR_W'(OFS_PERIOD): prdata = per_rd;
                ADDR_W'(OFS_COUNT):  prdata = cnt_rd;
                ADDR_W'(OFS_STATUS): prdata = {{(DATA_W-1){1'b0}}, irq};
                default:             prdata = '0;
            endcase
        end
    end

    // R8: the arm bit never falls outside reset
    a_r8_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> arm);

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W    = 32,
    parameter int SEL_W    = 4,
    parameter int BASE_EXP = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    localparam int SH_W = $clog2(CNT_W) + 1;

    logic [SH_W-1:0]  sh;
    logic [CNT_W-1:0] start_val;
    logic [CNT_W-1:0] cnt_q;

    assign sh        = SH_W'(BASE_EXP) + SH_W'(sel);
    assign start_val = CNT_W'(1) << sh;
    assign expire    = tick && (cnt_q <= CNT_W'(1));
    assign cnt       = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= start_val;
        end else if (tick) begin
            if (expire) cnt_q <= start_val;
            else        cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R2: a qualified cycle above one steps the count down by exactly one
    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R2: the count never lands on zero after a load or a tick
    a_r2_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick || load) |=> (cnt_q != '0));

    // R3: without a qualified cycle or reload the count holds
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             warn_first,
    input  logic [LEN_W-1:0] pulse_len,
    input  logic             kick_ok,
    input  logic             clr_irq,
    input  logic             expire,
    output logic             load,
    output logic             counting,
    output logic             irq,
    output logic             sys_rst
);

    wd_state_e        state_q, state_d;
    logic [LEN_W-1:0] rcnt_q;
    logic             irq_q, rst_q;

    assign counting = (state_q == ST_RUN) || (state_q == ST_WARN);
    assign irq      = irq_q;
    assign sys_rst  = rst_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (arm) begin                       // arm_start
                    state_d = ST_RUN;
                    load    = 1'b1;
                end
            end
            ST_RUN: begin
                if (kick_ok) begin                   // kick_reload
                    load = 1'b1;
                end else if (expire) begin           // first_expiry / hard_expiry
                    state_d = warn_first ? ST_WARN : ST_BITE;
                end
            end
            ST_WARN: begin
                if (kick_ok) begin                   // kick_rescue
                    state_d = ST_RUN;
                    load    = 1'b1;
                end else if (expire) begin           // second_expiry
                    state_d = ST_BITE;
                end
            end
            ST_BITE: begin
                if (rcnt_q == '0) begin              // pulse_done
                    state_d = ST_RUN;
                    load    = 1'b1;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            rst_q  <= 1'b0;
            rcnt_q <= '0;
        end else begin
            rst_q <= (state_d == ST_BITE);
            if (state_q == ST_RUN && state_d == ST_WARN) begin
                irq_q <= 1'b1;
            end else if (clr_irq || (kick_ok && counting) ||
                         (state_q == ST_BITE && state_d == ST_RUN)) begin
                irq_q <= 1'b0;
            end
            if (state_q != ST_BITE && state_d == ST_BITE) begin
                rcnt_q <= pulse_len;
            end else if (state_q == ST_BITE && rcnt_q != '0) begin
                rcnt_q <= rcnt_q - LEN_W'(1);
            end
        end
    end

    // R6: the interrupt only rises on entry to the warning state
    a_r6_irq_on_warn: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> (state_q == ST_WARN));

    // R5: an immediate-mode expiry goes straight to reset without an interrupt
    a_r5_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && expire && !kick_ok && !warn_first) |=> (sys_rst && !irq_q));

    // R7: the pulse ends when its length counter is spent
    a_r7_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BITE && rcnt_q == '0) |=> (!sys_rst && !irq_q));

    // R8: once left, the off state is never re-entered
    a_r8_no_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF) |=> (state_q != ST_OFF));

endmodule

// File: rtl/wdog_dual_stage.sv
module wdog_dual_stage #(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32,
    parameter int SEL_W     = 4,
    parameter int LEN_W     = 4,
    parameter int BASE_EXP  = 16,
    parameter int DEF_SEL   = 0,
    parameter int DEF_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              cnt_en,
    input  logic              pause,
    output logic              irq,
    output logic              sys_rst
);

    localparam int CNT_W = BASE_EXP + (1 << SEL_W);

    logic             arm, warn_first, kick_ok, clr_irq;
    logic [LEN_W-1:0] pulse_len;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] cnt;
    logic             expire, load, counting, tick;

    assign tick = counting & cnt_en & ~pause;

    wdog_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .LEN_W(LEN_W),
        .CNT_W(CNT_W), .DEF_SEL(DEF_SEL), .DEF_PULSE(DEF_PULSE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .cnt_val(cnt), .irq(irq),
        .arm(arm), .warn_first(warn_first), .pulse_len(pulse_len), .sel(sel),
        .kick_ok(kick_ok), .clr_irq(clr_irq)
    );

    wdog_count #(
        .CNT_W(CNT_W), .SEL_W(SEL_W), .BASE_EXP(BASE_EXP)
    ) u_count (
        .clk(clk), .rst_n(rst_n),
        .load(load), .tick(tick), .sel(sel),
        .cnt(cnt), .expire(expire)
    );

    wdog_fsm #(
        .LEN_W(LEN_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .arm(arm), .warn_first(warn_first), .pulse_len(pulse_len),
        .kick_ok(kick_ok), .clr_irq(clr_irq), .expire(expire),
        .load(load), .counting(counting), .irq(irq), .sys_rst(sys_rst)
    );

    // R4: the pause input freezes the counter unless a reload is under way
    a_r4_pause_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !load) |=> $stable(cnt));

    // R10: clearing the flag by a read never touches the count
    a_r10_clear_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_irq && !tick && !load) |=> $stable(cnt));

endmodule

// File: tb/test_wdog_dual_stage.sv
module test_wdog_dual_stage;

    localparam int BASE      = 2;
    localparam int DEF_SEL   = 1;
    localparam int DEF_PULSE = 3;
    localparam int LIMIT     = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        cnt_en = 1'b0, pause = 1'b0;
    logic        irq, sys_rst;

    int n_run = 0, n_fail = 0, cyc = 0;

    wdog_dual_stage #(
        .BASE_EXP(BASE), .DEF_SEL(DEF_SEL), .DEF_PULSE(DEF_PULSE)
    ) i_wdog_dual_stage (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .cnt_en(cnt_en), .pause(pause), .irq(irq), .sys_rst(sys_rst)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > LIMIT) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cyc, LIMIT);
            $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    function automatic int s_of(input int n);
        return 1 << (BASE + n);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; psel = 1'b0; penable = 1'b0; cnt_en = 1'b0; pause = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = int'(prdata);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // arm write plus the cycle in which the state machine takes the arm bit
    task automatic arm_it(input int mode, input int len);
        wr(5'h00, 32'(1 + (mode << 1) + (len << 8)));
        @(negedge clk);
    endtask

    // drive a pattern and count the qualified edges until the event shows
    task automatic run_until(input bit want_rst, input int pat, output int ticks);
        ticks = 0;
        for (int c = 0; c < 4000; c++) begin
            case (pat)
                1:       begin cnt_en = (c % 3 == 0); pause = 1'b0; end
                2:       begin cnt_en = 1'b1; pause = (c % 5 < 2); end
                default: begin cnt_en = 1'b1; pause = 1'b0; end
            endcase
            @(negedge clk);
            if (cnt_en && !pause) ticks++;
            if (want_rst ? sys_rst : irq) break;
        end
    endtask

    task automatic pulse_width(output int w);
        w = 1;
        for (int c = 0; c < 64; c++) begin
            @(negedge clk);
            if (sys_rst) w++;
            else break;
        end
    endtask

    int v, t, w;

    initial begin
        do_reset();

        // R1 reset state
        check("R1 irq", int'(irq), 0);
        check("R1 sys_rst", int'(sys_rst), 0);
        rd(5'h00, v); check("R1 ctrl", v, DEF_PULSE << 8);
        rd(5'h04, v); check("R1 period", v, DEF_SEL);
        rd(5'h0C, v); check("R1 count", v, 0);

        // R9 kick while unarmed does nothing
        wr(5'h08, 32'h76);
        rd(5'h0C, v); check("R9 unarmed kick count", v, 0);
        rd(5'h00, v); check("R9 unarmed kick arm", v & 1, 0);
        cnt_en = 1'b1; repeat (20) @(negedge clk);
        check("R9 unarmed no reset", int'(sys_rst | irq), 0);
        cnt_en = 1'b0;

        // R2 R3 R4 R11 load, step, gating, hold, period change, kick
        wr(5'h04, 32'd3);
        arm_it(0, 0);
        rd(5'h0C, v); check("R2 load", v, s_of(3));
        cnt_en = 1'b1; repeat (5) @(negedge clk); cnt_en = 1'b0;
        rd(5'h0C, v); check("R2 step", v, s_of(3) - 5);
        repeat (10) @(negedge clk);
        rd(5'h0C, v); check("R3 gated", v, s_of(3) - 5);
        cnt_en = 1'b1; pause = 1'b1; repeat (10) @(negedge clk);
        cnt_en = 1'b0; pause = 1'b0;
        rd(5'h0C, v); check("R4 paused", v, s_of(3) - 5);
        wr(5'h08, 32'h77); wr(5'h08, 32'h00);
        rd(5'h0C, v); check("R9 bad key", v, s_of(3) - 5);
        wr(5'h04, 32'd1);
        rd(5'h0C, v); check("R11 no effect mid-count", v, s_of(3) - 5);
        rd(5'h04, v); check("R11 period readback", v, 1);
        wr(5'h08, 32'h0000_0176);
        rd(5'h0C, v); check("R11 new start on kick", v, s_of(1));

        // R8 sticky arm
        wr(5'h00, 32'h0);
        rd(5'h00, v); check("R8 arm kept", v & 1, 1);
        run_until(1'b1, 0, t); check("R8 still times out", t, s_of(1));
        pulse_width(w); check("R7 len0 width", w, 1);

        // sweep: both modes, period exponents, count patterns
        for (int mode = 0; mode < 2; mode++) begin
            for (int n = 0; n < 5; n++) begin
                for (int pat = 0; pat < 3; pat++) begin
                    int len;
                    len = (n * 3 + pat) % 16;
                    do_reset();
                    wr(5'h04, 32'(n));
                    arm_it(mode, len);
                    if (mode == 0) begin
                        run_until(1'b1, pat, t); check("R5 period", t, s_of(n));
                        check("R5 no irq", int'(irq), 0);
                        pulse_width(w); check("R7 width", w, len + 1);
                        run_until(1'b1, pat, t); check("R7 resumes", t, s_of(n));
                    end else begin
                        run_until(1'b0, pat, t); check("R6 first timeout", t, s_of(n));
                        check("R6 no reset yet", int'(sys_rst), 0);
                        cnt_en = 1'b0; pause = 1'b0;
                        rd(5'h10, v); check("R10 status bit", v, 1);
                        check("R10 cleared", int'(irq), 0);
                        run_until(1'b1, pat, t); check("R6 second timeout", t, s_of(n));
                        pulse_width(w); check("R7 width", w, len + 1);
                        check("R7 irq low after", int'(irq), 0);
                        run_until(1'b0, pat, t); check("R7 resumes", t, s_of(n));
                    end
                end
            end
        end

        // R10 status read keeps count; R9 kick rescues from warning
        do_reset();
        wr(5'h04, 32'd1);
        arm_it(1, 2);
        run_until(1'b0, 0, t); check("R6 warn", t, s_of(1));
        cnt_en = 1'b1; repeat (3) @(negedge clk); cnt_en = 1'b0;
        rd(5'h10, v); check("R10 read", v, 1);
        rd(5'h0C, v); check("R10 count kept", v, s_of(1) - 3);
        check("R10 flag clear", int'(irq), 0);
        do_reset();
        wr(5'h04, 32'd1);
        arm_it(1, 2);
        run_until(1'b0, 0, t); check("R6 warn again", t, s_of(1));
        cnt_en = 1'b0;
        wr(5'h08, 32'h76);
        check("R9 kick clears irq", int'(irq), 0);
        rd(5'h0C, v); check("R9 kick reload", v, s_of(1));
        run_until(1'b0, 0, t); check("R9 back to first stage", t, s_of(1));
        check("R9 no reset after rescue", int'(sys_rst), 0);

        // R7 pulse length sweep
        for (int len = 0; len < 16; len++) begin
            do_reset();
            wr(5'h04, 32'd0);
            arm_it(0, len);
            run_until(1'b1, 0, t); check("R2 expiry", t, s_of(0));
            pulse_width(w); check("R7 pulse sweep", w, len + 1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule